// File: doc/BRIEF.md
# Power Domain Sequencer

This block owns three control words that steer a set of on-chip power domains: a power-down word (a 1 cuts the supply to the bits it covers), an isolation word whose bits are active-low (0 clamps the domain's outputs) and a unit reset word whose bits are active-low (0 holds the unit in reset). Each domain is described at build time by three masks that pick its bits out of those words. A mask of zero means the domain has no bit in that word.

A requester names one domain and a direction. The block then walks a fixed sequence, one clock per step, and touches only the selected domain's bits. To switch a domain off it clamps the isolators, then asserts reset, then sets the power-down bits. To switch a domain on it runs the reverse: it clears the power-down bits, then releases reset, then removes the clamps. An isolation or reset step whose mask is zero is dropped from the sequence. The power step always runs. The block raises `busy` for the whole sequence and pulses `done` at the end. Software can also read any of the three words and overwrite it directly while no sequence is running. A per-domain `dom_on` flag reports whether all of that domain's power-down bits are clear.

Top module: `pwr_domain_seq`

## Requirements
- R1: After reset the power-down word reads 0x00000000, the isolation and reset words read 0xFFFFFFFF, and `busy` and `done` are low.
- R2: A power-off request (`req_on`=0) for a domain with non-zero isolation and reset masks changes the words in three consecutive clocks after acceptance. The first clock clears its isolation bits, the second clears its reset bits and the third sets its power-down bits.
- R3: A power-on request (`req_on`=1) runs in three consecutive clocks after acceptance. The first clock clears the power-down bits, the second sets the reset bits and the third sets the isolation bits.
- R4: An isolation or reset step whose domain mask is zero is skipped and takes no clock. The power step is always performed, so a domain with only a power mask finishes its sequence in one step.
- R5: Every step changes only the bits inside the current domain's mask for the word that step acts on. All other bits of all three words keep their values.
- R6: `busy` is high from the clock after acceptance until `done` falls. `done` is high for exactly one clock, the clock after the last step.
- R7: A request that arrives while `busy` is high is ignored. It does not restart, extend or redirect the running sequence.
- R8: A request whose domain index is not below the number of domains is ignored. `busy` stays low and no word changes.
- R9: With `reg_we` high while idle, `reg_addr` 0, 1 or 2 writes `reg_wdata` to the power-down, isolation or reset word, and the new value shows at the next clock. `reg_rdata` shows the word that `reg_addr` selects. Address 3 reads zero, and a write to address 3 changes nothing.
- R10: A software write made while `busy` is high is ignored.
- R11: `dom_on[d]` is 1 exactly when the power-down word ANDed with domain d's power mask is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_valid | input | 1 | Request strobe, sampled for one clock |
| req_on | input | 1 | Direction: 1 powers the domain on, 0 powers it off |
| req_dom | input | DOM_W | Domain index of the request |
| reg_we | input | 1 | Software write strobe |
| reg_addr | input | 2 | Word select: 0 power-down, 1 isolation, 2 reset, 3 unused |
| reg_wdata | input | REG_W | Software write data |
| reg_rdata | output | REG_W | Selected word, combinational |
| pwr_down | output | REG_W | Power-down word, a 1 cuts the supply |
| iso_en_n | output | REG_W | Isolation word, a 0 clamps the domain's outputs |
| unit_rst_n | output | REG_W | Reset word, a 0 holds the unit in reset |
| dom_on | output | NUM_DOM | Per-domain powered flag |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-clock end-of-sequence pulse |

## Verification
The bench builds the block with three 32-bit-wide domains. Two domains have isolation, reset and power masks at separate bit positions. The third has only a power mask, so the skipped-step paths and the one-step sequence can be reached. Because the domain index is two bits wide, index 3 exists on the port and the out-of-range request can be exercised. The bench also fills the words with mixed patterns before the sequences run, so any bit outside a domain's mask that a step disturbs shows up on the outputs.

// File: rtl/pds_pkg.sv
package pds_pkg;

  // Sequencer position; the three middle values are also the step kinds.
  typedef enum logic [2:0] {
    STP_IDLE = 3'd0,
    STP_ISO  = 3'd1,
    STP_RST  = 3'd2,
    STP_PWR  = 3'd3,
    STP_DONE = 3'd4
  } step_e;

  // Software word select.
  typedef enum logic [1:0] {
    RA_PWR  = 2'd0,
    RA_ISO  = 2'd1,
    RA_RST  = 2'd2,
    RA_NONE = 2'd3
  } reg_addr_e;

endpackage

// File: rtl/pds_mask_sel.sv
module pds_mask_sel #(
  parameter int NUM_DOM = 3,
  parameter int REG_W   = 32,
  parameter int DOM_W   = 2,
  parameter logic [NUM_DOM*REG_W-1:0] PWR_MASKS = '0,
  parameter logic [NUM_DOM*REG_W-1:0] ISO_MASKS = '0,
  parameter logic [NUM_DOM*REG_W-1:0] RST_MASKS = '0
) (
  input  logic [DOM_W-1:0] sel,
  output logic [REG_W-1:0] m_pwr,
  output logic [REG_W-1:0] m_iso,
  output logic [REG_W-1:0] m_rst
);

  logic [REG_W-1:0] pwr_tab [NUM_DOM];
  logic [REG_W-1:0] iso_tab [NUM_DOM];
  logic [REG_W-1:0] rst_tab [NUM_DOM];

  for (genvar g = 0; g < NUM_DOM; g++) begin : g_tab
    assign pwr_tab[g] = PWR_MASKS[g*REG_W +: REG_W];
    assign iso_tab[g] = ISO_MASKS[g*REG_W +: REG_W];
    assign rst_tab[g] = RST_MASKS[g*REG_W +: REG_W];
  end

  always_comb begin
    m_pwr = '0;
    m_iso = '0;
    m_rst = '0;
    for (int i = 0; i < NUM_DOM; i++) begin
      if (sel == DOM_W'(i)) begin
        m_pwr = pwr_tab[i];
        m_iso = iso_tab[i];
        m_rst = rst_tab[i];
      end
    end
  end

endmodule

// File: rtl/pds_fsm.sv
module pds_fsm
  import pds_pkg::*;
#(
  parameter int NUM_DOM = 3,
  parameter int DOM_W   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_on,
  input  logic [DOM_W-1:0] req_dom,
  input  logic             iso_nz,
  input  logic             rst_nz,
  output logic             busy,
  output logic             done,
  output logic             step_en,
  output step_e            step,
  output logic             step_on,
  output logic [DOM_W-1:0] dom_q
);

  step_e            state_q, state_d;
  logic             on_q, on_d;
  logic [DOM_W-1:0] dom_d;
  logic             dom_ok;
  logic             accept;

  assign dom_ok = ({1'b0, req_dom} < (DOM_W+1)'(NUM_DOM));
  assign accept = (state_q == STP_IDLE) && req_valid && dom_ok;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      STP_IDLE: begin
        if (accept) begin
          if (req_on)      state_d = STP_PWR;
          else if (iso_nz) state_d = STP_ISO;
          else if (rst_nz) state_d = STP_RST;
          else             state_d = STP_PWR;
        end
      end
      STP_ISO: begin
        if (on_q)        state_d = STP_DONE;
        else if (rst_nz) state_d = STP_RST;
        else             state_d = STP_PWR;
      end
      STP_RST: begin
        if (!on_q)       state_d = STP_PWR;
        else if (iso_nz) state_d = STP_ISO;
        else             state_d = STP_DONE;
      end
      STP_PWR: begin
        if (!on_q)       state_d = STP_DONE;
        else if (rst_nz) state_d = STP_RST;
        else if (iso_nz) state_d = STP_ISO;
        else             state_d = STP_DONE;
      end
      STP_DONE: state_d = STP_IDLE;
      default:  state_d = STP_IDLE;
    endcase
  end

  assign on_d  = accept ? req_on  : on_q;
  assign dom_d = accept ? req_dom : dom_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= STP_IDLE;
      on_q    <= 1'b0;
      dom_q   <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        on_q  <= on_d;
        dom_q <= dom_d;
      end
    end
  end

  assign busy    = (state_q != STP_IDLE);
  assign done    = (state_q == STP_DONE);
  assign step_en = (state_q == STP_ISO) || (state_q == STP_RST) || (state_q == STP_PWR);
  assign step    = state_q;
  assign step_on = on_q;

  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6
  done_after_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(step_en));

  // R7
  busy_holds_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req_valid) |=> ($stable(dom_q) && $stable(on_q)));

  // R8
  bad_dom_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_valid && !dom_ok) |=> !busy);

endmodule

// File: rtl/pds_regfile.sv
module pds_regfile
  import pds_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busy,
  input  logic             sw_we,
  input  logic [1:0]       sw_addr,
  input  logic [REG_W-1:0] sw_wdata,
  input  logic             step_en,
  input  step_e            step,
  input  logic             step_on,
  input  logic [REG_W-1:0] m_pwr,
  input  logic [REG_W-1:0] m_iso,
  input  logic [REG_W-1:0] m_rst,
  output logic [REG_W-1:0] pwr_q,
  output logic [REG_W-1:0] iso_q,
  output logic [REG_W-1:0] rst_q,
  output logic [REG_W-1:0] rdata
);

  logic [REG_W-1:0] pwr_d, iso_d, rst_d;
  logic             sw_ok;
  logic             upd_en;

  assign sw_ok  = sw_we && !busy;
  assign upd_en = step_en || sw_ok;

  always_comb begin
    pwr_d = pwr_q;
    iso_d = iso_q;
    rst_d = rst_q;
    if (step_en) begin
      unique case (step)
        STP_ISO: iso_d = step_on ? (iso_q | m_iso) : (iso_q & ~m_iso);
        STP_RST: rst_d = step_on ? (rst_q | m_rst) : (rst_q & ~m_rst);
        STP_PWR: pwr_d = step_on ? (pwr_q & ~m_pwr) : (pwr_q | m_pwr);
        default: ;
      endcase
    end else if (sw_ok) begin
      unique case (reg_addr_e'(sw_addr))
        RA_PWR:  pwr_d = sw_wdata;
        RA_ISO:  iso_d = sw_wdata;
        RA_RST:  rst_d = sw_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_q <= '0;
      iso_q <= '1;
      rst_q <= '1;
    end else if (upd_en) begin
      pwr_q <= pwr_d;
      iso_q <= iso_d;
      rst_q <= rst_d;
    end
  end

  always_comb begin
    unique case (reg_addr_e'(sw_addr))
      RA_PWR:  rdata = pwr_q;
      RA_ISO:  rdata = iso_q;
      RA_RST:  rdata = rst_q;
      default: rdata = '0;
    endcase
  end

  // R5
  masked_bits_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_en |=> ((((pwr_q ^ $past(pwr_q)) & ~$past(m_pwr)) |
                  ((iso_q ^ $past(iso_q)) & ~$past(m_iso)) |
                  ((rst_q ^ $past(rst_q)) & ~$past(m_rst))) == '0));

  // R10
  busy_write_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !step_en) |=> ($stable(pwr_q) && $stable(iso_q) && $stable(rst_q)));

endmodule

// File: rtl/pwr_domain_seq.sv
module pwr_domain_seq
  import pds_pkg::*;
#(
  parameter int NUM_DOM = 3,
  parameter int REG_W   = 32,
  parameter logic [NUM_DOM*REG_W-1:0] PWR_MASKS = {32'h0000_0001, 32'h0000_0004, 32'h0000_0008},
  parameter logic [NUM_DOM*REG_W-1:0] ISO_MASKS = {32'h0000_0000, 32'h0000_0002, 32'h0000_0001},
  parameter logic [NUM_DOM*REG_W-1:0] RST_MASKS = {32'h0000_0000, 32'h0004_0000, 32'h0001_0000},
  localparam int DOM_W = (NUM_DOM > 1) ? $clog2(NUM_DOM) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_on,
  input  logic [DOM_W-1:0]   req_dom,
  input  logic               reg_we,
  input  logic [1:0]         reg_addr,
  input  logic [REG_W-1:0]   reg_wdata,
  output logic [REG_W-1:0]   reg_rdata,
  output logic [REG_W-1:0]   pwr_down,
  output logic [REG_W-1:0]   iso_en_n,
  output logic [REG_W-1:0]   unit_rst_n,
  output logic [NUM_DOM-1:0] dom_on,
  output logic               busy,
  output logic               done
);

  logic [1:0]       rsync_q;
  logic             srst_n;
  logic [DOM_W-1:0] dom_q;
  logic [DOM_W-1:0] mask_sel;
  logic [REG_W-1:0] m_pwr, m_iso, m_rst;
  logic             step_en, step_on;
  step_e            step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign srst_n = rsync_q[1];

  // While idle the masks describe the incoming request; while busy, the latched domain.
  assign mask_sel = busy ? dom_q : req_dom;

  pds_mask_sel #(
    .NUM_DOM(NUM_DOM), .REG_W(REG_W), .DOM_W(DOM_W),
    .PWR_MASKS(PWR_MASKS), .ISO_MASKS(ISO_MASKS), .RST_MASKS(RST_MASKS)
  ) u_masks (
    .sel   (mask_sel),
    .m_pwr (m_pwr),
    .m_iso (m_iso),
    .m_rst (m_rst)
  );

  pds_fsm #(.NUM_DOM(NUM_DOM), .DOM_W(DOM_W)) u_fsm (
    .clk       (clk),
    .rst_n     (srst_n),
    .req_valid (req_valid),
    .req_on    (req_on),
    .req_dom   (req_dom),
    .iso_nz    (|m_iso),
    .rst_nz    (|m_rst),
    .busy      (busy),
    .done      (done),
    .step_en   (step_en),
    .step      (step),
    .step_on   (step_on),
    .dom_q     (dom_q)
  );

  pds_regfile #(.REG_W(REG_W)) u_regs (
    .clk      (clk),
    .rst_n    (srst_n),
    .busy     (busy),
    .sw_we    (reg_we),
    .sw_addr  (reg_addr),
    .sw_wdata (reg_wdata),
    .step_en  (step_en),
    .step     (step),
    .step_on  (step_on),
    .m_pwr    (m_pwr),
    .m_iso    (m_iso),
    .m_rst    (m_rst),
    .pwr_q    (pwr_down),
    .iso_q    (iso_en_n),
    .rst_q    (unit_rst_n),
    .rdata    (reg_rdata)
  );

  for (genvar g = 0; g < NUM_DOM; g++) begin : g_on
    assign dom_on[g] = ~|(pwr_down & PWR_MASKS[g*REG_W +: REG_W]);
  end

  // R2
  off_order_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (step_en && step == STP_PWR && !step_on) |->
      (((iso_en_n & m_iso) == '0) && ((unit_rst_n & m_rst) == '0)));

  // R3
  on_order_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (step_en && step == STP_ISO && step_on) |->
      (((pwr_down & m_pwr) == '0) && ((unit_rst_n & m_rst) == m_rst)));

  // R4
  pwr_step_runs_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (done && !$past(done)) |-> $past(step_en));

endmodule

// File: tb/pwr_domain_seq_tb_top.sv
module pwr_domain_seq_tb_top;

  localparam int ND = 3;
  localparam logic [31:0] PM [ND] = '{32'h8, 32'h4, 32'h1};
  localparam logic [31:0] IM [ND] = '{32'h1, 32'h2, 32'h0};
  localparam logic [31:0] RM [ND] = '{32'h0001_0000, 32'h0004_0000, 32'h0};

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_on;
  logic [1:0]  req_dom;
  logic        reg_we;
  logic [1:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata, pwr_down, iso_en_n, unit_rst_n;
  logic [2:0]  dom_on;
  logic        busy, done;

  always #10 clk = ~clk;

  pwr_domain_seq #(
    .NUM_DOM(ND), .REG_W(32),
    .PWR_MASKS({PM[2], PM[1], PM[0]}),
    .ISO_MASKS({IM[2], IM[1], IM[0]}),
    .RST_MASKS({RM[2], RM[1], RM[0]})
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_on(req_on), .req_dom(req_dom),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pwr_down(pwr_down), .iso_en_n(iso_en_n), .unit_rst_n(unit_rst_n),
    .dom_on(dom_on), .busy(busy), .done(done)
  );

  // Behavioural reference model
  logic [31:0] m_pwr, m_iso, m_rst;
  logic        m_busy, m_done;
  int          m_dom;
  int          m_q[$];
  int          vectors = 0;
  int          fails = 0;
  int          cycles = 0;
  string       tag = "R1";
  bit          ended = 0;

  // codes: 0 clamp, 1 hold reset, 2 cut power, 3 restore power, 4 free reset, 5 unclamp
  function automatic void m_step(int code);
    case (code)
      0: m_iso = m_iso & ~IM[m_dom];
      1: m_rst = m_rst & ~RM[m_dom];
      2: m_pwr = m_pwr | PM[m_dom];
      3: m_pwr = m_pwr & ~PM[m_dom];
      4: m_rst = m_rst | RM[m_dom];
      default: m_iso = m_iso | IM[m_dom];
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pwr = 32'h0; m_iso = 32'hFFFF_FFFF; m_rst = 32'hFFFF_FFFF;
      m_busy = 0; m_done = 0; m_dom = 0; m_q.delete();
    end else if (!m_busy) begin
      if (reg_we) begin
        if (reg_addr == 2'd0) m_pwr = reg_wdata;
        else if (reg_addr == 2'd1) m_iso = reg_wdata;
        else if (reg_addr == 2'd2) m_rst = reg_wdata;
      end
      if (req_valid && int'(req_dom) < ND) begin
        m_dom = int'(req_dom);
        if (!req_on) begin
          if (IM[m_dom] != 0) m_q.push_back(0);
          if (RM[m_dom] != 0) m_q.push_back(1);
          m_q.push_back(2);
        end else begin
          m_q.push_back(3);
          if (RM[m_dom] != 0) m_q.push_back(4);
          if (IM[m_dom] != 0) m_q.push_back(5);
        end
        m_busy = 1;
      end
    end else if (m_q.size() > 0) begin
      m_step(m_q.pop_front());
      if (m_q.size() == 0) m_done = 1;
    end else begin
      m_done = 0;
      m_busy = 0;
    end
  end

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n === 1'b1 && !ended) begin
      logic [2:0]  e_on;
      logic [31:0] e_rd;
      for (int g = 0; g < ND; g++) e_on[g] = ((m_pwr & PM[g]) == 0);
      case (reg_addr)
        2'd0: e_rd = m_pwr;
        2'd1: e_rd = m_iso;
        2'd2: e_rd = m_rst;
        default: e_rd = 32'h0;
      endcase
      chk("pwr_down", pwr_down, m_pwr);
      chk("iso_en_n", iso_en_n, m_iso);
      chk("unit_rst_n", unit_rst_n, m_rst);
      chk("dom_on", {29'h0, dom_on}, {29'h0, e_on});
      chk("busy", {31'h0, busy}, {31'h0, m_busy});
      chk("done", {31'h0, done}, {31'h0, m_done});
      chk("reg_rdata", reg_rdata, e_rd);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !ended) begin
      ended = 1;
      fails++;
      $display("FAIL R6 watchdog: actual cycles=%0d expected below 20000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #5;
  endtask

  task automatic req(bit on, logic [1:0] dom);
    @(posedge clk); #5;
    req_valid = 1; req_on = on; req_dom = dom;
    @(posedge clk); #5;
    req_valid = 0;
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(posedge clk); #5;
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #5;
    reg_we = 0;
  endtask

  task automatic rd(logic [1:0] a);
    @(posedge clk); #5;
    reg_addr = a;
  endtask

  initial begin
    rst_n = 0; req_valid = 0; req_on = 0; req_dom = 0;
    reg_we = 0; reg_addr = 0; reg_wdata = 0;
    repeat (3) @(posedge clk);
    #5 rst_n = 1;
    // R1: reset values
    tag = "R1"; idle(4);
    rd(2'd1); rd(2'd2); rd(2'd0);
    // R2: power-off, full sequence
    tag = "R2"; req(0, 2'd0); idle(6);
    // R3: power-on, reverse sequence
    tag = "R3"; req(1, 2'd0); idle(6);
    // R4: domain with only a power mask
    tag = "R4"; req(0, 2'd2); idle(5); req(1, 2'd2); idle(5);
    // R5: other bits must survive the steps
    tag = "R5";
    wr(2'd0, 32'h0F0F_0000); wr(2'd1, 32'hFFFF_00F0); wr(2'd2, 32'hA5A5_5A5A);
    req(0, 2'd1); idle(6); req(1, 2'd1); idle(6);
    // R6: busy/done timing
    tag = "R6"; req(0, 2'd0); idle(6); req(1, 2'd0); idle(6);
    // R7: requests while busy
    tag = "R7"; req(0, 2'd1); req(1, 2'd0); req(0, 2'd0); req(1, 2'd2); idle(6);
    // R8: out-of-range domain
    tag = "R8"; req(0, 2'd3); idle(3); req(1, 2'd3); idle(3);
    // R9: software access
    tag = "R9";
    wr(2'd0, 32'h1234_0000); rd(2'd0);
    wr(2'd1, 32'hCAFE_F00D); rd(2'd1);
    wr(2'd2, 32'h0BAD_BEEF); rd(2'd2);
    wr(2'd3, 32'hFFFF_FFFF); rd(2'd3); rd(2'd0);
    // R10: software write during a sequence
    tag = "R10"; req(1, 2'd1); wr(2'd1, 32'h0); wr(2'd0, 32'hFFFF_FFFF); idle(6);
    // R11: powered flags
    tag = "R11"; wr(2'd0, 32'h0000_0004); idle(2); wr(2'd0, 32'h0000_0009); idle(2);
    wr(2'd0, 32'h0); idle(2);
    ended = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule